// File: doc/BRIEF.md
# Dual-Buffer Transmit Frame Controller

This block gives software two transmit packet buffers of 2 KiB each, reached over a 32-bit, word-aligned register bus. Software fills a buffer with frame bytes, writes the byte count into that buffer's length register, and then writes its control register. The control write starts one of two jobs. A plain start streams the buffer out as bytes on a valid/ready byte interface, with a last marker on the final byte. A start with the program bit also set copies the first six bytes of the buffer into the station MAC address output, and no byte is sent.

Each buffer's control word reads back busy while its job runs, and software can poll it until the block clears it. Jobs share a single engine. A start on one buffer while the other is running waits its turn. When a job finishes, a one-cycle interrupt pulse is raised. The pulse needs two enables: the finished buffer's own enable bit and one global enable that lives only beside buffer 0. The upper 4 KiB of the 8 KiB address window belong to receive logic that is not part of this block.

Top module: `dual_txbuf_ctrl`

## Requirements
- R1: After reset, both control words, both length registers and the global enable read 0. `tx_valid` and `irq` are low, and `mac_addr` equals the `MAC_DEFAULT` parameter.
- R2: Buffer words live at byte offsets 0x0000–0x07F0 (buffer 0) and 0x0800–0x0FF0 (buffer 1), excluding the register words below. A word written there reads back with `bus_rvalid` one cycle after the read request.
- R3: A control write (buffer 0 at 0x07FC, buffer 1 at 0x0FFC) with bit 0 set and bit 1 clear streams that buffer's bytes from byte 0 upward. Each word is sent least-significant byte first, and the number of bytes comes from the length register (buffer 0 at 0x07F4, buffer 1 at 0x0FF4). `tx_last` is high on the final byte only.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold unchanged.
- R5: A control write with bits 0 and 1 both set loads `mac_addr` from the first six buffer bytes, with byte 0 in bits 7:0 and byte 5 in bits 47:40. No byte appears on the stream.
- R6: A control word reads bit 0 (and bit 1 for a MAC load) as 1 while its job runs. Both bits read 0 after completion, and bit 3 keeps its written value.
- R7: One cycle after a job completes, `irq` pulses for exactly one cycle, but only if bit 3 of that buffer's control word and bit 31 of the register at 0x07F8 are both set. The matching word at 0x0FF8 is plain buffer memory with no effect on `irq`.
- R8: A control write to a buffer whose job is running is ignored entirely, including its bit 3.
- R9: A start on one buffer while the other buffer's job runs is held. It runs after that job completes, and its frame follows the earlier one on the stream. If both wait at once, buffer 0 goes first.
- R10: A length of 0 completes with no byte sent. A length above 2048 is treated as 2048.
- R11: Accesses whose address bits 1:0 are not zero, and accesses at 0x1000 and above, write nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one word |
| bus_rd | input | 1 | Read request for one word |
| bus_addr | input | ADDR_W | Byte address in the 8 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after a read request |
| tx_valid | output | 1 | Stream byte is valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte this cycle |
| irq | output | 1 | One-cycle completion pulse |
| mac_addr | output | 48 | Station MAC address |

## Verification
The case that matters most is a bus access and a running job touching the same storage in the same cycle. While buffer 0 streams with a randomly stalling sink, the bench reads buffer 0 memory, writes buffer 1 memory and its length, and starts buffer 1. It then checks three things: the streamed bytes match the contents from before those accesses, the read returns the stored word, and buffer 1's frame follows directly on the stream. A second collision writes the running buffer's control word, trying a MAC load and an enable change mid-stream. The bench judges this by the unchanged `mac_addr`, the busy readback, an intact frame and the absence of an interrupt.

// File: rtl/txb_pkg.sv
package txb_pkg;
  // control word bit positions (software visible)
  localparam int CTL_GO  = 0;
  localparam int CTL_PRG = 1;
  localparam int CTL_IE  = 3;
  localparam int GIE_BIT = 31;

  typedef enum logic [2:0] {
    E_IDLE, E_RD, E_LAT, E_SEND, E_MRD0, E_MLAT0, E_MLAT1, E_DONE
  } eng_state_t;
endpackage

// File: rtl/txb_ram.sv
// Two-port word memory: port A read/write for the bus, port B read for the engine.
module txb_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      else      a_rdata     <= mem[a_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (b_en) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/txb_engine.sv
// Shared job engine: streams a buffer or loads the MAC address from it.
module txb_engine
  import txb_pkg::*;
#(
  parameter int           BUF_BYTES   = 2048,
  parameter int           LEN_W       = 16,
  parameter logic [47:0]  MAC_DEFAULT = 48'h02005E102030,
  localparam int          WORDS       = BUF_BYTES / 4,
  localparam int          AW          = $clog2(WORDS),
  localparam int          CW          = $clog2(BUF_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            go,
  input  logic [1:0]            prg,
  input  logic [1:0][LEN_W-1:0] len,
  output logic                  b_en,
  output logic [AW:0]           b_addr,
  input  logic [31:0]           b_rdata,
  output logic                  tx_valid,
  output logic [7:0]            tx_data,
  output logic                  tx_last,
  input  logic                  tx_ready,
  output logic                  done,
  output logic                  done_buf,
  output logic [47:0]           mac_addr
);
  eng_state_t       state;
  logic             sel;
  logic [AW-1:0]    wptr;
  logic [1:0]       bidx;
  logic [1:0]       nidx;
  logic [CW-1:0]    rem;
  logic [31:0]      word_q;
  logic [31:0]      w0_q;
  logic             pick;
  logic [LEN_W-1:0] len_pick;
  logic [CW-1:0]    len_eff;

  // fixed priority: buffer 0 before buffer 1
  always_comb begin
    pick     = !go[0];
    len_pick = len[pick];
    len_eff  = (len_pick > LEN_W'(BUF_BYTES)) ? CW'(BUF_BYTES) : CW'(len_pick);
    nidx     = bidx + 2'd1;
  end

  always_comb begin
    b_en   = 1'b0;
    b_addr = {sel, wptr};
    unique case (state)
      E_RD:    b_en = 1'b1;
      E_MRD0:  begin b_en = 1'b1; b_addr = {sel, AW'(0)}; end
      E_MLAT0: begin b_en = 1'b1; b_addr = {sel, AW'(1)}; end
      default: ;
    endcase
  end

  assign done     = (state == E_DONE);
  assign done_buf = sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= E_IDLE;
      sel      <= 1'b0;
      wptr     <= '0;
      bidx     <= '0;
      rem      <= '0;
      word_q   <= '0;
      w0_q     <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_last  <= 1'b0;
      mac_addr <= MAC_DEFAULT;
    end else begin
      unique case (state)
        E_IDLE: if (|go) begin
          sel  <= pick;
          wptr <= '0;
          rem  <= len_eff;
          if (prg[pick])          state <= E_MRD0;
          else if (len_eff == '0) state <= E_DONE;
          else                    state <= E_RD;
        end
        E_RD: state <= E_LAT;
        E_LAT: begin
          word_q   <= b_rdata;
          tx_valid <= 1'b1;
          tx_data  <= b_rdata[7:0];
          tx_last  <= (rem == CW'(1));
          bidx     <= '0;
          state    <= E_SEND;
        end
        E_SEND: if (tx_ready) begin
          rem <= rem - CW'(1);
          if (rem == CW'(1)) begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            state    <= E_DONE;
          end else if (bidx == 2'd3) begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            wptr     <= wptr + AW'(1);
            state    <= E_RD;
          end else begin
            bidx    <= nidx;
            tx_data <= word_q[{nidx, 3'b000} +: 8];
            tx_last <= (rem == CW'(2));
          end
        end
        E_MRD0: state <= E_MLAT0;
        E_MLAT0: begin
          w0_q  <= b_rdata;
          state <= E_MLAT1;
        end
        E_MLAT1: begin
          mac_addr <= {b_rdata[15:0], w0_q};
          state    <= E_DONE;
        end
        E_DONE: state <= E_IDLE;
        default: state <= E_IDLE;
      endcase
    end
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  p_last_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  p_mac_source_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(mac_addr) |-> $past(state == E_MLAT1));
endmodule

// File: rtl/dual_txbuf_ctrl.sv
module dual_txbuf_ctrl
  import txb_pkg::*;
#(
  parameter int          BUF_BYTES   = 2048,
  parameter int          LEN_W       = 16,
  parameter logic [47:0] MAC_DEFAULT = 48'h02005E102030,
  localparam int         WORDS       = BUF_BYTES / 4,
  localparam int         AW          = $clog2(WORDS),
  localparam int         ADDR_W      = AW + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              irq,
  output logic [47:0]       mac_addr
);
  localparam logic [AW-1:0] LEN_OFS = AW'(WORDS - 3);
  localparam logic [AW-1:0] GIE_OFS = AW'(WORDS - 2);
  localparam logic [AW-1:0] CTL_OFS = AW'(WORDS - 1);

  logic                  aligned, in_tx, acc_ok, bsel;
  logic [AW-1:0]         wofs;
  logic                  hit_len, hit_gie, hit_ctl, hit_ram;
  logic                  ram_en;
  logic [31:0]           ram_rdata, reg_val, reg_rdata_q;
  logic                  use_ram_q;
  logic                  b_en;
  logic [AW:0]           b_addr;
  logic [31:0]           b_rdata;
  logic [1:0][LEN_W-1:0] len_q;
  logic [1:0]            go_q, prg_q, ie_q;
  logic                  gie_q;
  logic                  eng_done, eng_buf;
  logic                  wr_ctl;

  always_comb begin
    aligned = (bus_addr[1:0] == 2'b00);
    in_tx   = !bus_addr[ADDR_W-1];
    acc_ok  = aligned && in_tx;
    bsel    = bus_addr[ADDR_W-2];
    wofs    = bus_addr[ADDR_W-3:2];
    hit_len = (wofs == LEN_OFS);
    hit_ctl = (wofs == CTL_OFS);
    hit_gie = (wofs == GIE_OFS) && !bsel;
    hit_ram = !(hit_len || hit_ctl || hit_gie);
    ram_en  = acc_ok && hit_ram && (bus_wr || bus_rd);
    wr_ctl  = bus_wr && acc_ok && hit_ctl;
  end

  always_comb begin
    reg_val = '0;
    if (acc_ok) begin
      if (hit_len)      reg_val = {{(32-LEN_W){1'b0}}, len_q[bsel]};
      else if (hit_gie) reg_val = {gie_q, 31'b0};
      else if (hit_ctl) reg_val = {28'b0, ie_q[bsel], 1'b0, prg_q[bsel], go_q[bsel]};
    end
  end

  txb_ram #(.DW(32), .DEPTH(2 * WORDS)) u_ram (
    .clk     (clk),
    .a_en    (ram_en),
    .a_we    (bus_wr),
    .a_addr  ({bsel, wofs}),
    .a_wdata (bus_wdata),
    .a_rdata (ram_rdata),
    .b_en    (b_en),
    .b_addr  (b_addr),
    .b_rdata (b_rdata)
  );

  txb_engine #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .MAC_DEFAULT(MAC_DEFAULT)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .go       (go_q),
    .prg      (prg_q),
    .len      (len_q),
    .b_en     (b_en),
    .b_addr   (b_addr),
    .b_rdata  (b_rdata),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .tx_ready (tx_ready),
    .done     (eng_done),
    .done_buf (eng_buf),
    .mac_addr (mac_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      go_q  <= '0;
      prg_q <= '0;
      ie_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (eng_done && (eng_buf == 1'(b))) begin
          go_q[b]  <= 1'b0;
          prg_q[b] <= 1'b0;
        end
      end
      if (bus_wr && acc_ok) begin
        if (hit_len) len_q[bsel] <= bus_wdata[LEN_W-1:0];
        if (hit_gie) gie_q <= bus_wdata[GIE_BIT];
      end
      // a start on a busy buffer is dropped; done on the same edge wins
      if (wr_ctl && !go_q[bsel]) begin
        ie_q[bsel]  <= bus_wdata[CTL_IE];
        go_q[bsel]  <= bus_wdata[CTL_GO];
        prg_q[bsel] <= bus_wdata[CTL_GO] && bus_wdata[CTL_PRG];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid  <= 1'b0;
      use_ram_q   <= 1'b0;
      reg_rdata_q <= '0;
      irq         <= 1'b0;
    end else begin
      bus_rvalid  <= bus_rd && !bus_wr;
      use_ram_q   <= ram_en && !bus_wr;
      reg_rdata_q <= reg_val;
      irq         <= eng_done && ie_q[eng_buf] && gie_q;
    end
  end

  assign bus_rdata = use_ram_q ? ram_rdata : reg_rdata_q;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[30:LEN_W], bus_wdata[2]};

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(eng_done) && $past(gie_q)));

  p_busy_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && go_q[bsel]) |=> (ie_q == $past(ie_q)));

  for (genvar g = 0; g < 2; g++) begin : g_buf_chk
    p_clear_on_done_r6: assert property (@(posedge clk) disable iff (rst)
      $fell(go_q[g]) |-> $past(eng_done && (eng_buf == 1'(g))));
  end
endmodule

// File: tb/dual_txbuf_ctrl_tb.sv
`timescale 1ns/1ps
module dual_txbuf_ctrl_tb;
  localparam logic [47:0] MACD = 48'h02005E102030;
  localparam logic [12:0] A_LEN0 = 13'h07F4, A_GIE = 13'h07F8, A_CTL0 = 13'h07FC;
  localparam logic [12:0] A_LEN1 = 13'h0FF4, A_GIE1 = 13'h0FF8, A_CTL1 = 13'h0FFC;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, tx_valid, tx_last, irq;
  logic tx_ready = 0;
  logic [7:0] tx_data;
  logic [47:0] mac_addr;

  int n_chk = 0, n_err = 0, irq_cnt = 0, hold_err = 0, rdy_pct = 7, cyc = 0;
  logic [31:0] mdl [2][512];
  logic [8:0] got_q[$];
  logic prev_stall = 0, prev_last = 0;
  logic [7:0] prev_data = '0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  dual_txbuf_ctrl u_dut (.*);

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      tx_ready = (($urandom % 10) < rdy_pct);
      if (prev_stall && (!tx_valid || tx_data != prev_data || tx_last != prev_last)) hold_err++;
      if (tx_valid && tx_ready) got_q.push_back({tx_last, tx_data});
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      prev_last  = tx_last;
      if (irq) irq_cnt++;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // tasks are entered just after a falling edge
  task automatic bwr(input logic [12:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic brd(input logic [12:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic wword(input int b, input int w, input logic [31:0] d);
    bwr(13'(b * 2048 + w * 4), d);
    mdl[b][w] = d;
  endtask

  function automatic logic [7:0] exp_byte(input int b, input int i);
    return mdl[b][i / 4][(i % 4) * 8 +: 8];
  endfunction

  task automatic wait_idle(input int b);
    for (int k = 0; k < 20000; k++) begin
      brd(b ? A_CTL1 : A_CTL0, rd);
      if (!rd[0]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_frame(input int b, input int n, input int base, input int dlim, input string tag);
    int bad = 0, lastbad = 0;
    for (int i = 0; i < n; i++) begin
      if (base + i >= got_q.size()) begin bad++; continue; end
      if (i < dlim && got_q[base + i][7:0] != exp_byte(b, i)) bad++;
      if (got_q[base + i][8] != (i == n - 1)) lastbad++;
    end
    chk(bad == 0, {tag, " bytes"}, 64'(bad), 0);
    chk(lastbad == 0, {tag, " last flag"}, 64'(lastbad), 0);
  endtask

  task automatic clear_obs();
    got_q.delete();
    irq_cnt = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    brd(A_CTL0, rd); chk(rd == 0, "R1 ctrl0", rd, 0);
    brd(A_CTL1, rd); chk(rd == 0, "R1 ctrl1", rd, 0);
    brd(A_LEN0, rd); chk(rd == 0, "R1 len0", rd, 0);
    brd(A_GIE, rd);  chk(rd == 0, "R1 gie", rd, 0);
    chk(!tx_valid && !irq, "R1 outputs idle", {tx_valid, irq}, 0);
    chk(mac_addr == MACD, "R1 mac default", mac_addr, MACD);

    // R2 memory fill and readback
    for (int w = 0; w < 509; w++) wword(0, w, $urandom);
    for (int w = 0; w < 80; w++) wword(1, w, $urandom);
    brd(13'h0010, rd); chk(rd == mdl[0][4], "R2 buf0 word4", rd, mdl[0][4]);
    brd(13'h0800 + 13'd40, rd); chk(rd == mdl[1][10], "R2 buf1 word10", rd, mdl[1][10]);
    bus_rd = 1; bus_addr = 13'h0020; @(negedge clk); bus_rd = 0;
    chk(bus_rvalid == 1, "R2 rvalid", bus_rvalid, 1);

    // R11 unaligned and out-of-window
    bwr(13'h1000, 32'hDEADBEEF); brd(13'h1000, rd); chk(rd == 0, "R11 upper window", rd, 0);
    bwr(13'h0001, 32'h12345678); brd(13'h0000, rd); chk(rd == mdl[0][0], "R11 unaligned write", rd, mdl[0][0]);
    brd(13'h0006, rd); chk(rd == 0, "R11 unaligned read", rd, 0);

    // R3/R6/R7 basic transmit with irq
    clear_obs();
    bwr(A_GIE, 32'h8000_0000);
    bwr(A_LEN0, 37);
    bwr(A_CTL0, 32'h9);
    brd(A_CTL0, rd); chk(rd == 32'h9, "R6 busy readback", rd, 32'h9);
    wait_idle(0);
    chk(got_q.size() == 37, "R3 byte count", got_q.size(), 37);
    check_frame(0, 37, 0, 37, "R3 frame");
    brd(A_CTL0, rd); chk(rd == 32'h8, "R6 cleared after done", rd, 32'h8);
    chk(irq_cnt == 1, "R7 irq pulse", irq_cnt, 1);

    // R8 busy control write ignored
    clear_obs();
    rdy_pct = 3;
    bwr(A_LEN0, 200);
    bwr(A_CTL0, 32'h1);
    bwr(A_CTL0, 32'hB);
    brd(A_CTL0, rd); chk(rd == 32'h1, "R8 busy write dropped", rd, 32'h1);
    wait_idle(0);
    chk(mac_addr == MACD, "R8 mac unchanged", mac_addr, MACD);
    chk(got_q.size() == 200, "R8 byte count", got_q.size(), 200);
    check_frame(0, 200, 0, 200, "R8 frame");
    chk(irq_cnt == 0, "R8 ie not taken", irq_cnt, 0);
    rdy_pct = 7;

    // R9 concurrent bus traffic and queued second buffer
    clear_obs();
    bwr(A_LEN0, 100);
    bwr(A_CTL0, 32'h9);
    brd(13'h0014, rd); chk(rd == mdl[0][5], "R9 read during stream", rd, mdl[0][5]);
    wword(1, 70, $urandom);
    bwr(A_LEN1, 20);
    bwr(A_CTL1, 32'h9);
    wait_idle(0); wait_idle(1);
    chk(got_q.size() == 120, "R9 total bytes", got_q.size(), 120);
    check_frame(0, 100, 0, 100, "R9 first frame");
    check_frame(1, 20, 100, 20, "R9 second frame");
    chk(irq_cnt == 2, "R9 two completions", irq_cnt, 2);

    // R7 global enable off; 0x0FF8 is memory only
    clear_obs();
    bwr(A_GIE, 0);
    wword(1, 510, 32'h8000_0000);
    bwr(A_LEN1, 8);
    bwr(A_CTL1, 32'h9);
    wait_idle(1);
    chk(irq_cnt == 0, "R7 gated by global", irq_cnt, 0);
    brd(A_GIE1, rd); chk(rd == 32'h8000_0000, "R7 0xFF8 is memory", rd, 32'h8000_0000);
    check_frame(1, 8, 0, 8, "R7 frame");

    // R5 MAC load
    clear_obs();
    wword(1, 0, 32'hA1B2C3D4);
    wword(1, 1, 32'h9988E5F6);
    bwr(A_CTL1, 32'h3);
    wait_idle(1);
    chk(mac_addr == 48'hE5F6A1B2C3D4, "R5 mac load", mac_addr, 48'hE5F6A1B2C3D4);
    chk(got_q.size() == 0, "R5 no bytes", got_q.size(), 0);
    brd(A_CTL1, rd); chk(rd == 0, "R6 prg cleared", rd, 0);

    // R10 zero length and clamp
    clear_obs();
    bwr(A_LEN0, 0);
    bwr(A_CTL0, 32'h1);
    wait_idle(0);
    chk(got_q.size() == 0, "R10 zero length", got_q.size(), 0);
    brd(A_CTL0, rd); chk(rd == 0, "R10 zero length done", rd, 0);
    clear_obs();
    bwr(A_LEN0, 32'h2000);
    bwr(A_CTL0, 32'h1);
    wait_idle(0);
    chk(got_q.size() == 2048, "R10 clamp count", got_q.size(), 2048);
    check_frame(0, 2048, 0, 2036, "R10 clamp frame");

    // random frames
    for (int it = 0; it < 8; it++) begin
      int b = $urandom % 2;
      int n = 1 + $urandom % 160;
      logic ie = 1'($urandom), ge = 1'($urandom);
      clear_obs();
      for (int w = 0; w < (n + 3) / 4; w++) wword(b, w, $urandom);
      bwr(A_GIE, {ge, 31'b0});
      bwr(b ? A_LEN1 : A_LEN0, 32'(n));
      bwr(b ? A_CTL1 : A_CTL0, {28'b0, ie, 3'b001});
      wait_idle(b);
      chk(got_q.size() == n, "R3 random count", got_q.size(), n);
      check_frame(b, n, 0, n, "R3 random");
      chk(irq_cnt == int'(ie && ge), "R7 random irq", irq_cnt, int'(ie && ge));
    end

    chk(hold_err == 0, "R4 stall hold", hold_err, 0);
    finish_run();
  end
endmodule